// File: doc/BRIEF.md
# Transaction Nesting Commit Controller

This controller follows the nesting of hardware-transaction regions for one processor core. Region-begin strobes raise the depth, and the first of them captures the fallback address. Region-end strobes lower the depth. Only the end that brings the depth back to zero asks the memory system to commit, through a request/acknowledge handshake that returns pass or fail.

Several conditions roll the transaction back:
- a failed commit,
- an end issued while suspend-tracking is on,
- a begin beyond the maximum depth,
- an external abort strobe.

Each of these takes the same path. It pulses a rollback request and a redirect strobe, presents the saved outermost fallback address, writes a cause into the status word and clears the depth, the active flag and the suspend flag.

Malformed ends do not execute. They raise single-cycle fault strobes: an undefined-opcode fault when the feature is disabled or a lock prefix is present, and a general-protection fault when no region is open. Every output is a register and changes on the clock edge that samples the stimulus.

Top module: `txn_nest_ctrl`

## Requirements
- R1: A synchronous reset clears the active flag, depth, busy, commit request, suspend flag, status word and fallback address, and holds every strobe low.
- R2: A begin while inactive sets active, sets the depth to 1 and latches the fallback address input, which then appears on redirectAddr.
- R3: A begin while active and below depth 7 adds one to the depth and leaves redirectAddr unchanged. A begin at depth 7 aborts with status 8'h11 (bit 4 = depth overflow).
- R4: An end with featEn=0 or lockPfx=1 pulses udFault for one cycle and changes no state. This fault wins over the inactive fault.
- R5: An end while inactive, with featEn=1 and lockPfx=0, pulses gpFault for one cycle and changes no state.
- R6: An end while the suspend flag is set aborts with status 8'h09 (bit 3 = suspend-tracking end).
- R7: An end at depth greater than 1 lowers the depth by one, keeps active set and does not request a commit.
- R8: An end at depth 1 sets the depth to 0 and raises commitReq and busy. These stay high until commitAck. While busy, all commands, suspend updates and external aborts are ignored.
- R9: commitAck with commitOk=1 clears active, busy and commitReq without a rollback, and leaves the status word unchanged.
- R10: commitAck with commitOk=0 aborts with status 8'h05 (bit 2 = commit failure).
- R11: An abort pulses rollbackReq and redirect for exactly one cycle, leaves redirectAddr at the outermost begin's address, and clears depth, active and the suspend flag. It sets status to bit 0 plus exactly one cause bit.
- R12: extAbort while active and not busy aborts with status 8'h03 (bit 1 = external) and overrides any command in the same cycle. extAbort is ignored while inactive.
- R13: suspSet and suspClr update suspActive only while active and not busy, and only in a cycle that neither aborts nor starts a commit. When both are high, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| featEn | input | 1 | Transaction feature enabled |
| lockPfx | input | 1 | Lock prefix present on the end command |
| beginCmd | input | 1 | Region-begin strobe |
| endCmd | input | 1 | Region-end strobe (takes precedence over beginCmd) |
| fallbackAddr | input | ADDR_W | Fallback address offered with a begin |
| suspSet | input | 1 | Turn suspend-tracking on |
| suspClr | input | 1 | Turn suspend-tracking off |
| extAbort | input | 1 | External abort strobe |
| commitAck | input | 1 | Commit result valid |
| commitOk | input | 1 | Commit result: 1 = pass |
| active | output | 1 | A transaction is open |
| depth | output | DEPTH_W | Current nesting depth |
| busy | output | 1 | Waiting for a commit result |
| commitReq | output | 1 | Commit request to the memory system |
| udFault | output | 1 | Undefined-opcode fault pulse |
| gpFault | output | 1 | General-protection fault pulse |
| rollbackReq | output | 1 | Register restore and write discard pulse |
| redirect | output | 1 | Redirect-to-fallback pulse |
| redirectAddr | output | ADDR_W | Saved outermost fallback address |
| status | output | 8 | Last abort status |
| suspActive | output | 1 | Suspend-tracking flag |

## Verification
Each result is due on the first clock edge after the stimulus is sampled: fault pulses, depth, active, status, rollback and redirect all appear after that single register stage. The commit outcome appears one edge after the commitAck cycle. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It then compares every output at the following falling edge, so each check lands exactly one cycle after its cause. Directed sequences cover the overflow, suspend, commit-fail, fault-priority and busy-ignore cases. A seeded random phase then mixes all commands against the same model.

// File: rtl/txn_nest_pkg.sv
package txn_nest_pkg;

  localparam int STAT_W    = 8;
  localparam int CAUSE_N   = 4;
  localparam int BIT_ANY   = 0;
  localparam int CAUSE_LSB = 1;

  // Control state: bit 0 = region open, bit 1 = commit pending
  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_RUN  = 2'b01,
    ST_WAIT = 2'b11
  } txn_state_e;

  // One-hot abort cause; packed so ext lands on status bit 1 ... nest on bit 4
  typedef struct packed {
    logic nest;
    logic susp;
    logic cfail;
    logic ext;
  } cause_t;

  typedef struct packed {
    logic   firstBegin;
    logic   incDepth;
    logic   decDepth;
    logic   doAbort;
    cause_t cause;
    logic   suspWr;
    logic   suspVal;
  } ctl_t;

endpackage

// File: rtl/txn_nest_ctrl_fsm.sv
module txn_nest_ctrl_fsm
  import txn_nest_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic featEn,
  input  logic lockPfx,
  input  logic beginCmd,
  input  logic endCmd,
  input  logic suspSet,
  input  logic suspClr,
  input  logic extAbort,
  input  logic commitAck,
  input  logic commitOk,
  input  logic depthIsOne,
  input  logic depthAtMax,
  input  logic suspQ,
  output ctl_t ctl,
  output logic activeQ,
  output logic busyQ,
  output logic udFaultQ,
  output logic gpFaultQ,
  output logic rollbackQ,
  output logic redirectQ
);

  txn_state_e stateQ, stateD;
  logic udD, gpD;
  logic badEnc;

  assign badEnc = !featEn || lockPfx;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    udD    = 1'b0;
    gpD    = 1'b0;
    unique case (stateQ)
      ST_WAIT: begin
        if (commitAck) begin
          if (commitOk) begin
            stateD = ST_OFF;
          end else begin
            ctl.doAbort   = 1'b1;
            ctl.cause.cfail = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (extAbort) begin
          ctl.doAbort   = 1'b1;
          ctl.cause.ext = 1'b1;
        end else begin
          if (endCmd) begin
            if (badEnc) begin
              udD = 1'b1;
            end else if (suspQ) begin
              ctl.doAbort    = 1'b1;
              ctl.cause.susp = 1'b1;
            end else begin
              ctl.decDepth = 1'b1;
              if (depthIsOne) stateD = ST_WAIT;
            end
          end else if (beginCmd) begin
            if (depthAtMax) begin
              ctl.doAbort    = 1'b1;
              ctl.cause.nest = 1'b1;
            end else begin
              ctl.incDepth = 1'b1;
            end
          end
          if (!ctl.doAbort && stateD == ST_RUN && (suspSet || suspClr)) begin
            ctl.suspWr  = 1'b1;
            ctl.suspVal = suspSet;
          end
        end
      end
      default: begin
        if (endCmd) begin
          if (badEnc) udD = 1'b1;
          else        gpD = 1'b1;
        end else if (beginCmd) begin
          ctl.firstBegin = 1'b1;
          stateD         = ST_RUN;
        end
      end
    endcase
    if (ctl.doAbort) stateD = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_OFF;
      udFaultQ  <= 1'b0;
      gpFaultQ  <= 1'b0;
      rollbackQ <= 1'b0;
      redirectQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      udFaultQ  <= udD;
      gpFaultQ  <= gpD;
      rollbackQ <= ctl.doAbort;
      redirectQ <= ctl.doAbort;
    end
  end

  assign activeQ = stateQ[0];
  assign busyQ   = stateQ[1];

  // R4: the encoding fault and the inactive fault never fire together
  assert_fault_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(udFaultQ && gpFaultQ));

  // R5: an inactive fault leaves the controller closed
  assert_gp_closed_R5: assert property (@(posedge clk) disable iff (rst)
    gpFaultQ |-> (stateQ == ST_OFF));

  // R8: the commit request is held until acknowledged
  assert_commit_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !commitAck) |=> busyQ);

  // R11: after an abort no region is open
  assert_abort_closed_R11: assert property (@(posedge clk) disable iff (rst)
    rollbackQ |-> (stateQ == ST_OFF));

endmodule

// File: rtl/txn_nest_ctrl_dp.sv
module txn_nest_ctrl_dp
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_t               ctl,
  input  logic [ADDR_W-1:0]  fallbackAddr,
  output logic [DEPTH_W-1:0] depthQ,
  output logic [ADDR_W-1:0]  savedAddrQ,
  output logic [STAT_W-1:0]  statusQ,
  output logic               suspQ,
  output logic               depthIsOne,
  output logic               depthAtMax
);

  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_TOP = DEPTH_W'(MAX_DEPTH);

  logic [STAT_W-1:0]  statusD;
  logic [CAUSE_N-1:0] causeVec;

  assign causeVec = ctl.cause;
  assign statusD[BIT_ANY] = 1'b1;

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    assign statusD[CAUSE_LSB + i] = causeVec[i];
  end
  for (genvar j = CAUSE_LSB + CAUSE_N; j < STAT_W; j++) begin : g_pad
    assign statusD[j] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depthQ     <= '0;
      savedAddrQ <= '0;
      statusQ    <= '0;
      suspQ      <= 1'b0;
    end else if (ctl.doAbort) begin
      depthQ  <= '0;
      suspQ   <= 1'b0;
      statusQ <= statusD;
    end else begin
      if (ctl.firstBegin) begin
        depthQ     <= DEPTH_ONE;
        savedAddrQ <= fallbackAddr;
      end else if (ctl.incDepth) begin
        depthQ <= depthQ + DEPTH_ONE;
      end else if (ctl.decDepth) begin
        depthQ <= depthQ - DEPTH_ONE;
      end
      if (ctl.suspWr) suspQ <= ctl.suspVal;
    end
  end

  assign depthIsOne = (depthQ == DEPTH_ONE);
  assign depthAtMax = (depthQ == DEPTH_TOP);

  // R3: depth never exceeds the configured maximum
  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (rst)
    depthQ <= DEPTH_TOP);

  // R11: an abort request empties depth and the suspend flag
  assert_abort_zero_R11: assert property (@(posedge clk) disable iff (rst)
    ctl.doAbort |=> (depthQ == '0 && !suspQ));

  // R11: status after an abort carries bit 0 and one cause bit
  assert_status_cause_R11: assert property (@(posedge clk) disable iff (rst)
    ctl.doAbort |=> ($countones(statusQ) == 2 && statusQ[BIT_ANY]));

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DEPTH = 7,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               featEn,
  input  logic               lockPfx,
  input  logic               beginCmd,
  input  logic               endCmd,
  input  logic [ADDR_W-1:0]  fallbackAddr,
  input  logic               suspSet,
  input  logic               suspClr,
  input  logic               extAbort,
  input  logic               commitAck,
  input  logic               commitOk,
  output logic               active,
  output logic [DEPTH_W-1:0] depth,
  output logic               busy,
  output logic               commitReq,
  output logic               udFault,
  output logic               gpFault,
  output logic               rollbackReq,
  output logic               redirect,
  output logic [ADDR_W-1:0]  redirectAddr,
  output logic [STAT_W-1:0]  status,
  output logic               suspActive
);

  ctl_t ctl;
  logic depthIsOne, depthAtMax, suspQ, busyQ;

  txn_nest_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .featEn     (featEn),
    .lockPfx    (lockPfx),
    .beginCmd   (beginCmd),
    .endCmd     (endCmd),
    .suspSet    (suspSet),
    .suspClr    (suspClr),
    .extAbort   (extAbort),
    .commitAck  (commitAck),
    .commitOk   (commitOk),
    .depthIsOne (depthIsOne),
    .depthAtMax (depthAtMax),
    .suspQ      (suspQ),
    .ctl        (ctl),
    .activeQ    (active),
    .busyQ      (busyQ),
    .udFaultQ   (udFault),
    .gpFaultQ   (gpFault),
    .rollbackQ  (rollbackReq),
    .redirectQ  (redirect)
  );

  txn_nest_ctrl_dp #(
    .ADDR_W    (ADDR_W),
    .MAX_DEPTH (MAX_DEPTH),
    .DEPTH_W   (DEPTH_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .fallbackAddr (fallbackAddr),
    .depthQ       (depth),
    .savedAddrQ   (redirectAddr),
    .statusQ      (status),
    .suspQ        (suspQ),
    .depthIsOne   (depthIsOne),
    .depthAtMax   (depthAtMax)
  );

  assign busy       = busyQ;
  assign commitReq  = busyQ;
  assign suspActive = suspQ;

  // R3: a nested begin keeps the outermost fallback address
  assert_inner_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (active && !busyQ && beginCmd && !endCmd && !extAbort) |=> $stable(redirectAddr));

  // R11: rollback is a single-cycle pulse
  assert_rollback_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rollbackReq |=> !rollbackReq);

  // R12: an external abort on an inactive controller does nothing
  assert_ext_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!active && !beginCmd && extAbort) |=> !rollbackReq);

endmodule

// File: tb/txn_nest_ctrl_tb.sv
module txn_nest_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst, featEn, lockPfx, beginCmd, endCmd, suspSet, suspClr;
  logic        extAbort, commitAck, commitOk;
  logic [31:0] fallbackAddr;
  logic        active, busy, commitReq, udFault, gpFault, rollbackReq, redirect, suspActive;
  logic [2:0]  depth;
  logic [31:0] redirectAddr;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  bit          mActive, mBusy, mSusp, eUd, eGp, eRb;
  int          mDepth;
  logic [31:0] mAddr;
  logic [7:0]  mStatus;

  always #5 clk = ~clk;

  txn_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .featEn(featEn), .lockPfx(lockPfx),
    .beginCmd(beginCmd), .endCmd(endCmd), .fallbackAddr(fallbackAddr),
    .suspSet(suspSet), .suspClr(suspClr), .extAbort(extAbort),
    .commitAck(commitAck), .commitOk(commitOk),
    .active(active), .depth(depth), .busy(busy), .commitReq(commitReq),
    .udFault(udFault), .gpFault(gpFault), .rollbackReq(rollbackReq),
    .redirect(redirect), .redirectAddr(redirectAddr), .status(status),
    .suspActive(suspActive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mAbort(input logic [7:0] code);
    mDepth = 0; mActive = 0; mSusp = 0; mBusy = 0;
    mStatus = code; eRb = 1;
  endtask

  // Advances the model with the inputs present at a rising edge
  task automatic modelStep();
    bit oldActive, oldBusy;
    oldActive = mActive; oldBusy = mBusy;
    eUd = 0; eGp = 0; eRb = 0;
    if (rst) begin
      mActive = 0; mBusy = 0; mSusp = 0; mDepth = 0; mAddr = '0; mStatus = '0;
    end else if (oldBusy) begin
      if (commitAck) begin
        if (commitOk) begin mBusy = 0; mActive = 0; end
        else mAbort(8'h05);
      end
    end else if (oldActive && extAbort) begin
      mAbort(8'h03);
    end else begin
      if (endCmd) begin
        if (!featEn || lockPfx) eUd = 1;
        else if (!oldActive) eGp = 1;
        else if (mSusp) mAbort(8'h09);
        else if (mDepth == 1) begin mDepth = 0; mBusy = 1; end
        else mDepth--;
      end else if (beginCmd) begin
        if (!oldActive) begin mActive = 1; mDepth = 1; mAddr = fallbackAddr; end
        else if (mDepth == 7) mAbort(8'h11);
        else mDepth++;
      end
      if (oldActive && !eRb && !mBusy && (suspSet || suspClr)) mSusp = suspSet;
    end
  endtask

  task automatic compareAll();
    chk("R2 active", 32'(active), 32'(mActive));
    chk("R3 depth", 32'(depth), 32'(mDepth));
    chk("R4 udFault", 32'(udFault), 32'(eUd));
    chk("R5 gpFault", 32'(gpFault), 32'(eGp));
    chk("R8 busy", 32'(busy), 32'(mBusy));
    chk("R8 commitReq", 32'(commitReq), 32'(mBusy));
    chk("R11 rollbackReq", 32'(rollbackReq), 32'(eRb));
    chk("R11 redirect", 32'(redirect), 32'(eRb));
    chk("R11 redirectAddr", redirectAddr, mAddr);
    chk("R11 status", 32'(status), 32'(mStatus));
    chk("R13 suspActive", 32'(suspActive), 32'(mSusp));
  endtask

  task automatic idle();
    featEn = 1; lockPfx = 0; beginCmd = 0; endCmd = 0; suspSet = 0; suspClr = 0;
    extAbort = 0; commitAck = 0; commitOk = 0;
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    idle();
  endtask

  task automatic doBegin(input logic [31:0] a);
    beginCmd = 1; fallbackAddr = a; step();
  endtask

  task automatic doEnd();
    endCmd = 1; step();
  endtask

  initial begin
    int w;
    for (w = 0; w < 200000 && !done; w++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", w, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2e3f40));
    idle(); fallbackAddr = '0; rst = 1;
    @(negedge clk);
    step(); rst = 1; step(); rst = 0;
    // R1 reset state
    chk("R1 active", 32'(active), 0);
    chk("R1 depth", 32'(depth), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 commitReq", 32'(commitReq), 0);

    // R2 first begin, R3 nested begin keeps address
    doBegin(32'hA000_0000);
    chk("R2 depth", 32'(depth), 1);
    chk("R2 redirectAddr", redirectAddr, 32'hA000_0000);
    doBegin(32'hB000_0000);
    chk("R3 depth", 32'(depth), 2);
    chk("R3 redirectAddr kept", redirectAddr, 32'hA000_0000);

    // R7 inner end
    doEnd();
    chk("R7 depth", 32'(depth), 1);
    chk("R7 no commitReq", 32'(commitReq), 0);

    // R4 encoding faults
    featEn = 0; doEnd();
    chk("R4 udFault featEn", 32'(udFault), 1);
    chk("R4 depth unchanged", 32'(depth), 1);
    lockPfx = 1; doEnd();
    chk("R4 udFault lock", 32'(udFault), 1);

    // R8 outer end starts commit; begin while busy ignored
    doEnd();
    chk("R8 commitReq", 32'(commitReq), 1);
    chk("R8 depth", 32'(depth), 0);
    doBegin(32'hCC00_0000);
    chk("R8 busy ignores begin", 32'(depth), 0);
    extAbort = 1; step();
    chk("R8 busy ignores extAbort", 32'(rollbackReq), 0);
    // R9 commit pass
    commitAck = 1; commitOk = 1; step();
    chk("R9 active", 32'(active), 0);
    chk("R9 no rollback", 32'(rollbackReq), 0);
    chk("R9 status kept", 32'(status), 0);

    // R5 inactive end, and R4 priority over it
    doEnd();
    chk("R5 gpFault", 32'(gpFault), 1);
    featEn = 0; doEnd();
    chk("R4 priority ud", 32'(udFault), 1);
    chk("R4 priority no gp", 32'(gpFault), 0);

    // R12 external abort
    extAbort = 1; step();
    chk("R12 idle ignore", 32'(rollbackReq), 0);
    doBegin(32'hC000_0000);
    doBegin(32'hC100_0000);
    extAbort = 1; endCmd = 1; step();
    chk("R12 status", 32'(status), 32'h03);
    chk("R12 redirectAddr", redirectAddr, 32'hC000_0000);
    chk("R12 redirect", 32'(redirect), 1);

    // R13 suspend flag, R6 end while suspended
    doBegin(32'hD000_0000);
    suspSet = 1; step();
    chk("R13 set", 32'(suspActive), 1);
    suspSet = 1; suspClr = 1; step();
    chk("R13 set wins", 32'(suspActive), 1);
    suspClr = 1; step();
    chk("R13 clear", 32'(suspActive), 0);
    suspSet = 1; step();
    doEnd();
    chk("R6 status", 32'(status), 32'h09);
    chk("R6 suspActive cleared", 32'(suspActive), 0);
    chk("R6 rollbackReq", 32'(rollbackReq), 1);

    // R3 depth overflow
    for (int i = 0; i < 7; i++) doBegin(32'hE000_0000 + 32'(i));
    chk("R3 depth max", 32'(depth), 7);
    doBegin(32'hEEEE_0000);
    chk("R3 overflow status", 32'(status), 32'h11);
    chk("R3 overflow redirectAddr", redirectAddr, 32'hE000_0000);

    // R10 commit fail, R11 single pulse
    doBegin(32'hF000_0000);
    doEnd();
    step();
    chk("R8 request held", 32'(commitReq), 1);
    commitAck = 1; commitOk = 0; step();
    chk("R10 status", 32'(status), 32'h05);
    chk("R10 rollbackReq", 32'(rollbackReq), 1);
    step();
    chk("R11 pulse ends", 32'(rollbackReq), 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(99));
      featEn   = ($urandom_range(99) < 95);
      lockPfx  = ($urandom_range(99) < 5);
      endCmd   = (r < 25);
      beginCmd = (r >= 25 && r < 60);
      extAbort = ($urandom_range(99) < 3);
      suspSet  = ($urandom_range(99) < 6);
      suspClr  = ($urandom_range(99) < 6);
      commitAck = ($urandom_range(99) < 40);
      commitOk  = ($urandom_range(99) < 70);
      fallbackAddr = $urandom();
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule